// File: doc/BRIEF.md
# Privilege-Aware Interrupt Arbiter

This block decides, once per clock, whether a hart should take an interrupt, to which privilege level it goes, and which cause number wins. It looks at the current privilege level, the machine and supervisor global enable bits, a pending vector, a per-cause enable vector and a delegation mask. It then presents a registered take request with the target level and the cause index. The trap-entry sequencer samples these outputs. Saving state, writing the trap registers and forming the handler address are done elsewhere.

The global enable bits are not applied blindly. An interrupt whose target level is more privileged than the running level is always globally enabled. An interrupt whose target level is less privileged is never taken. The target level's enable bit matters only when the hart is already running at that level. Each cause routes to supervisor level when its delegation bit is set, and to machine level when it is clear.

Top module: `irq_take_arb`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `take_o`=0, `target_o`=0 and `cause_o`=0.
- R2: The outputs are registered. They reflect the inputs sampled at the previous rising edge, with exactly one cycle of latency.
- R3: A cause with its `deleg_i` bit set targets supervisor level (`target_o`=2'b01). A cause with the bit clear targets machine level (`target_o`=2'b11).
- R4: While running at machine level (`mode_i`=2'b11), a delegated cause is never taken, whatever the value of `sie_i`.
- R5: A cause targeting a level above the running level is taken regardless of that level's enable bit. This covers machine-targeted causes in user level (2'b00) and in supervisor level (2'b01), and supervisor-targeted causes in user level.
- R6: When the running level equals the target level, the cause is taken only if that level's enable bit is set: `mie_i` for machine level, `sie_i` for supervisor level.
- R7: When both a machine-targeted and a supervisor-targeted cause qualify, the machine-targeted cause is reported.
- R8: Within one target level, causes rank in this order: 11, 3, 7, 9, 1, 5. All remaining cause numbers follow, from the highest number down.
- R9: `take_o` is 1 only if the reported cause has both its `pend_i` and `en_i` bits set. When `take_o` is 0, `target_o` and `cause_o` are both 0.
- R10: The reserved level encoding `mode_i`=2'b10 is handled exactly as machine level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Running privilege level: 00 user, 01 supervisor, 11 machine, 10 reserved |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| pend_i | input | NCAUSE | Pending bit per cause |
| en_i | input | NCAUSE | Enable bit per cause |
| deleg_i | input | NCAUSE | Delegation bit per cause (1 routes to supervisor level) |
| take_o | output | 1 | Take an interrupt this cycle |
| target_o | output | 2 | Level that receives the interrupt (01 or 11), 00 when idle |
| cause_o | output | $clog2(NCAUSE) | Winning cause index, 0 when idle |

## Verification
The bench aims at the case where the running level equals the target level, which is the only place an enable bit should matter. A design that applies `mie_i` unconditionally would lose a machine timer interrupt raised in user level with MIE clear. A design that ignores the level would take delegated causes while in machine level. Mixed vectors hold a machine cause that is pending but masked by its enable bit next to an enabled supervisor cause. These expose an arbiter that chooses the target before checking enables, or one that lets supervisor-targeted causes outrank machine-targeted ones. Directed rank sweeps catch a permuted priority list, and the reserved level encoding is checked so that it cannot fall through to user-level behaviour.

// File: rtl/irq_take_pkg.sv
package irq_take_pkg;

    typedef enum logic [1:0] {
        LVL_USER = 2'b00,
        LVL_SUPV = 2'b01,
        LVL_RSVD = 2'b10,
        LVL_MACH = 2'b11
    } priv_lvl_e;

    typedef struct packed {
        logic mach_on;
        logic supv_on;
    } gate_t;

    typedef struct packed {
        logic      hit;
        priv_lvl_e level;
    } route_t;

    localparam int NUM_FIXED = 6;

    // Map the raw level input to the effective level; reserved acts as machine.
    function automatic priv_lvl_e norm_level(input logic [1:0] raw);
        priv_lvl_e lv;
        if (raw == 2'b10) lv = LVL_MACH;
        else              lv = priv_lvl_e'(raw);
        return lv;
    endfunction

    // Fixed head of the rank list: ext, soft, timer for machine flavour, then supervisor flavour.
    function automatic int fixed_cause(input int r);
        int c;
        case (r)
            0: c = 11;
            1: c = 3;
            2: c = 7;
            3: c = 9;
            4: c = 1;
            default: c = 5;
        endcase
        return c;
    endfunction

    function automatic bit is_fixed(input int c);
        bit f;
        f = 1'b0;
        for (int k = 0; k < NUM_FIXED; k++)
            if (fixed_cause(k) == c) f = 1'b1;
        return f;
    endfunction

    // Cause number that sits at rank r (0 = highest priority) for n causes.
    function automatic int cause_at_rank(input int r, input int n);
        int cnt;
        int res;
        res = 0;
        if (r < NUM_FIXED) begin
            res = fixed_cause(r);
        end else begin
            cnt = NUM_FIXED;
            for (int c = n - 1; c >= 0; c--) begin
                if (!is_fixed(c)) begin
                    if (cnt == r) res = c;
                    cnt++;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_take_pkg::*;
(
    input  priv_lvl_e level_i,
    input  logic      mie_i,
    input  logic      sie_i,
    output gate_t     gate_o
);
    // Higher target: always open; same target: own enable; lower target: closed.
    always_comb begin
        gate_o = '0;
        unique case (level_i)
            LVL_USER: begin
                gate_o.mach_on = 1'b1;
                gate_o.supv_on = 1'b1;
            end
            LVL_SUPV: begin
                gate_o.mach_on = 1'b1;
                gate_o.supv_on = sie_i;
            end
            default: begin
                gate_o.mach_on = mie_i;
                gate_o.supv_on = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_rank_pick.sv
module irq_rank_pick
    import irq_take_pkg::*;
#(
    parameter int NCAUSE = 16,
    localparam int CW = $clog2(NCAUSE)
) (
    input  logic [NCAUSE-1:0] cand_i,
    output logic              hit_o,
    output logic [CW-1:0]     idx_o
);
    logic [NCAUSE-1:0] ranked;
    logic [CW-1:0]     rank_cause [NCAUSE];

    for (genvar r = 0; r < NCAUSE; r++) begin : g_rank
        localparam int CAUSE = cause_at_rank(r, NCAUSE);
        assign ranked[r]     = cand_i[CAUSE];
        assign rank_cause[r] = CW'(CAUSE);
    end

    // Scan from lowest rank upward so the best rank is written last.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int r = NCAUSE - 1; r >= 0; r--) begin
            if (ranked[r]) begin
                hit_o = 1'b1;
                idx_o = rank_cause[r];
            end
        end
    end
endmodule

// File: rtl/irq_take_arb.sv
module irq_take_arb
    import irq_take_pkg::*;
#(
    parameter int NCAUSE = 16,
    localparam int CW = $clog2(NCAUSE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              mie_i,
    input  logic              sie_i,
    input  logic [NCAUSE-1:0] pend_i,
    input  logic [NCAUSE-1:0] en_i,
    input  logic [NCAUSE-1:0] deleg_i,
    output logic              take_o,
    output logic [1:0]        target_o,
    output logic [CW-1:0]     cause_o
);
    priv_lvl_e         cur_lvl;
    gate_t             gate;
    logic [NCAUSE-1:0] live;
    logic [NCAUSE-1:0] mach_cand;
    logic [NCAUSE-1:0] supv_cand;
    logic              mach_hit;
    logic              supv_hit;
    logic [CW-1:0]     mach_idx;
    logic [CW-1:0]     supv_idx;
    route_t            route_d;
    logic [CW-1:0]     cause_d;
    logic              armed;

    assign cur_lvl   = norm_level(mode_i);
    assign live      = pend_i & en_i;
    assign mach_cand = live & ~deleg_i;
    assign supv_cand = live & deleg_i;

    irq_level_gate u_gate (
        .level_i (cur_lvl),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .gate_o  (gate)
    );

    irq_rank_pick #(.NCAUSE(NCAUSE)) u_pick_m (
        .cand_i (mach_cand),
        .hit_o  (mach_hit),
        .idx_o  (mach_idx)
    );

    irq_rank_pick #(.NCAUSE(NCAUSE)) u_pick_s (
        .cand_i (supv_cand),
        .hit_o  (supv_hit),
        .idx_o  (supv_idx)
    );

    // Machine-targeted winner first, supervisor second.
    always_comb begin
        route_d = '{hit: 1'b0, level: LVL_USER};
        cause_d = '0;
        if (mach_hit && gate.mach_on) begin
            route_d = '{hit: 1'b1, level: LVL_MACH};
            cause_d = mach_idx;
        end else if (supv_hit && gate.supv_on) begin
            route_d = '{hit: 1'b1, level: LVL_SUPV};
            cause_d = supv_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o   <= 1'b0;
            target_o <= 2'b00;
            cause_o  <= '0;
            armed    <= 1'b0;
        end else begin
            take_o   <= route_d.hit;
            target_o <= route_d.level;
            cause_o  <= cause_d;
            armed    <= 1'b1;
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk) rst |=> (!take_o && target_o == 2'b00)); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (target_o == 2'b00 && cause_o == '0)); // R9

    AST_CAUSE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (armed && take_o) |-> ((($past(pend_i & en_i) >> cause_o) & 1) == 1)); // R9

    AST_TARGET_DELEG: assert property (@(posedge clk) disable iff (rst)
        (armed && take_o) |-> ((target_o == 2'b01) == ((($past(deleg_i) >> cause_o) & 1) == 1))); // R3

    AST_NO_LOWER: assert property (@(posedge clk) disable iff (rst)
        (armed && take_o && $past(mode_i[1])) |-> target_o == 2'b11); // R4

    AST_HIGHER_ON: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(mode_i == 2'b00 && (pend_i & en_i & ~deleg_i) != '0))
        |-> (take_o && target_o == 2'b11)); // R5

    AST_OWN_GATE: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(mode_i == 2'b01 && !sie_i)) |-> !(take_o && target_o == 2'b01)); // R6

endmodule

// File: tb/test_irq_take_arb.sv
`timescale 1ns/1ps
module test_irq_take_arb;
    localparam int N  = 16;
    localparam int CW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    mode;
    logic          mie, sie;
    logic [N-1:0]  pend, en, deleg;
    logic          take;
    logic [1:0]    target;
    logic [CW-1:0] cause;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    irq_take_arb #(.NCAUSE(N)) i_irq_take_arb (
        .clk(clk), .rst(rst), .mode_i(mode), .mie_i(mie), .sie_i(sie),
        .pend_i(pend), .en_i(en), .deleg_i(deleg),
        .take_o(take), .target_o(target), .cause_o(cause)
    );

    function automatic int rank_list(input int r);
        int head [6] = '{11, 3, 7, 9, 1, 5};
        int cnt;
        int res;
        bit skip;
        res = 0;
        if (r < 6) return head[r];
        cnt = 6;
        for (int c = N - 1; c >= 0; c--) begin
            skip = 1'b0;
            for (int k = 0; k < 6; k++) if (head[k] == c) skip = 1'b1;
            if (!skip) begin
                if (cnt == r) res = c;
                cnt++;
            end
        end
        return res;
    endfunction

    // Reference: independent evaluation of the requirements.
    function automatic void model(input logic [1:0] md, input logic me, input logic se,
                                  input logic [N-1:0] p, input logic [N-1:0] e,
                                  input logic [N-1:0] d,
                                  output logic tk, output logic [1:0] tg, output logic [CW-1:0] cs);
        bit m_ok, s_ok;
        bit is_mach;
        int c;
        is_mach = (md == 2'b11) || (md == 2'b10);
        m_ok = is_mach ? me : 1'b1;
        s_ok = (md == 2'b00) ? 1'b1 : (md == 2'b01) ? se : 1'b0;
        tk = 1'b0; tg = 2'b00; cs = '0;
        for (int r = 0; r < N && !tk; r++) begin
            c = rank_list(r);
            if (p[c] && e[c] && !d[c] && m_ok) begin tk = 1'b1; tg = 2'b11; cs = CW'(c); end
        end
        for (int r = 0; r < N && !tk; r++) begin
            c = rank_list(r);
            if (p[c] && e[c] && d[c] && s_ok) begin tk = 1'b1; tg = 2'b01; cs = CW'(c); end
        end
    endfunction

    task automatic check(input string tag, input logic tk, input logic [1:0] tg, input logic [CW-1:0] cs);
        n_run++;
        if (take !== tk || target !== tg || cause !== cs) begin
            n_fail++;
            $display("FAIL %s: got take=%0b target=%0b cause=%0d, expected take=%0b target=%0b cause=%0d",
                     tag, take, target, cause, tk, tg, cs);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic apply(input string tag, input logic [1:0] md, input logic me, input logic se,
                         input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d);
        logic tk; logic [1:0] tg; logic [CW-1:0] cs;
        mode = md; mie = me; sie = se; pend = p; en = e; deleg = d;
        model(md, me, se, p, e, d, tk, tg, cs);
        @(negedge clk);
        check(tag, tk, tg, cs);
    endtask

    localparam logic [N-1:0] B11 = N'(1) << 11;
    localparam logic [N-1:0] B9  = N'(1) << 9;
    localparam logic [N-1:0] B7  = N'(1) << 7;
    localparam logic [N-1:0] B5  = N'(1) << 5;
    localparam logic [N-1:0] B3  = N'(1) << 3;
    localparam logic [N-1:0] B1  = N'(1) << 1;
    localparam logic [N-1:0] ALL = '1;

    initial begin
        rst = 1'b1; mode = 2'b00; mie = 1'b1; sie = 1'b1;
        pend = ALL; en = ALL; deleg = '0;
        @(negedge clk);
        @(negedge clk);
        check("R1", 1'b0, 2'b00, '0);
        rst = 1'b0;

        // R5: machine timer raised in user level with MIE clear is still taken.
        apply("R5", 2'b00, 1'b0, 1'b0, B7, ALL, '0);
        apply("R5", 2'b01, 1'b0, 1'b0, B11, ALL, '0);
        apply("R5", 2'b00, 1'b0, 1'b0, B9, ALL, B9);
        // R4: delegated causes blocked at machine level.
        apply("R4", 2'b11, 1'b1, 1'b1, B9 | B1 | B5, ALL, ALL);
        // R6: own-level enable gating.
        apply("R6", 2'b11, 1'b0, 1'b1, B3, ALL, '0);
        apply("R6", 2'b11, 1'b1, 1'b0, B3, ALL, '0);
        apply("R6", 2'b01, 1'b1, 1'b0, B5, ALL, B5);
        apply("R6", 2'b01, 1'b0, 1'b1, B5, ALL, B5);
        // R3: delegation chooses target.
        apply("R3", 2'b00, 1'b1, 1'b1, B1, ALL, B1);
        apply("R3", 2'b00, 1'b1, 1'b1, B1, ALL, '0);
        // R7: machine target outranks supervisor target of higher rank.
        apply("R7", 2'b00, 1'b1, 1'b1, B9 | B5, ALL, B9);
        apply("R7", 2'b01, 1'b0, 1'b1, B11 | B1, ALL, B11);
        // R8: rank order sweeps.
        apply("R8", 2'b11, 1'b1, 1'b0, B3 | B7 | B9 | B1 | B5, ALL, '0);
        apply("R8", 2'b11, 1'b1, 1'b0, B7 | B9 | B1 | B5 | B11, ALL, '0);
        apply("R8", 2'b00, 1'b0, 1'b0, B1 | B5 | 16'h5000, ALL, ALL);
        apply("R8", 2'b00, 1'b0, 1'b0, 16'h1014, ALL, '0);
        // R9: masked pending and empty vectors.
        apply("R9", 2'b00, 1'b1, 1'b1, B11, ~B11, '0);
        apply("R9", 2'b00, 1'b1, 1'b1, B11 | B5, ~B11, B5);
        apply("R9", 2'b01, 1'b1, 1'b1, '0, ALL, '0);
        // R10: reserved encoding behaves as machine level.
        apply("R10", 2'b10, 1'b0, 1'b1, B7, ALL, '0);
        apply("R10", 2'b10, 1'b1, 1'b1, B7, ALL, '0);
        apply("R10", 2'b10, 1'b1, 1'b1, B9, ALL, B9);

        // R2: back-to-back changes, each visible one cycle later.
        begin
            int seed;
            seed = 32'h1D2C;
            void'($urandom(seed));
            for (int i = 0; i < 3000; i++) begin
                logic [1:0] md;
                md = 2'($urandom);
                apply("R2", md, 1'($urandom), 1'($urandom),
                      N'($urandom & $urandom), N'($urandom | $urandom), N'($urandom));
            end
        end

        // R1: reset mid-run clears outputs even with a qualifying cause present.
        mode = 2'b00; pend = ALL; en = ALL; deleg = '0; rst = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 2'b00, '0);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule